// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry-Out

This block sits on the operand path of an integer datapath. It takes the second operand of an arithmetic or logic operation and shifts or rotates it by a variable amount before the ALU consumes it. It also produces a shifter carry that the flag logic can load into the carry flag. The block is purely combinational. A result is valid in the same cycle that its inputs are.

The shift distance has two possible sources. One is a 5-bit immediate field. The other is the low byte of a 32-bit register value. A select input chooses between them. Five operations are offered: a left shift, two kinds of right shift, a rotate, and a one-place rotate through the incoming carry. The zero and oversize distances that a register source can produce are defined for every operation.

Top module: `operand_shifter`

## Requirements
- R1: With a selected distance of zero, for operation codes 0 to 3, op_out equals op_in and carry_out equals carry_in.
- R2: Code 0 (left shift) by 1 to 31 places fills the low bits with zeros. carry_out is op_in[32-n].
- R3: Code 1 (logical right shift) by 1 to 31 places fills the high bits with zeros. carry_out is op_in[n-1].
- R4: Code 2 (arithmetic right shift) by 1 to 31 places fills the high bits with op_in[31]. carry_out is op_in[n-1].
- R5: Code 3 (rotate right) by a distance that is not a multiple of 32 rotates the operand by the distance modulo 32. carry_out equals the new op_out[31].
- R6: Code 4 (rotate through carry) ignores the distance. op_out is {carry_in, op_in[31:1]} and carry_out is op_in[0].
- R7: A logical shift (code 0 or 1) by exactly 32 gives zero. carry_out is op_in[0] for code 0 and op_in[31] for code 1.
- R8: A logical shift by 33 to 255 places gives zero with carry_out 0.
- R9: An arithmetic right shift by 32 to 255 places gives every bit and carry_out equal to op_in[31].
- R10: A rotate right by a nonzero multiple of 32 returns op_in unchanged, with carry_out equal to op_in[31].
- R11: When amt_from_reg is 1, the distance is reg_amt[7:0] and bits 31:8 have no effect. When amt_from_reg is 0, the distance is imm_amt and reg_amt has no effect.
- R12: Operation codes 5 to 7 pass op_in and carry_in through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_in | input | 32 | Operand to be shifted |
| shift_op | input | 3 | Operation code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 rotate through carry |
| amt_from_reg | input | 1 | 1 selects reg_amt as the distance, 0 selects imm_amt |
| imm_amt | input | 5 | Immediate shift distance |
| reg_amt | input | 32 | Register value whose low byte is the distance |
| carry_in | input | 1 | Current carry flag |
| op_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry for the flag logic |

## Verification
The operand result and the carry result always come out in the same evaluation. At the distance boundaries 0, 32 and above 32, and at multiples of 32 for rotates, both change their rule together. The bench provokes this with register distances drawn mostly from {0, 31, 32, 33, 64, 96, 255} and with both distance sources, under random operands and carries. Each case is judged by comparing the 33-bit pair {carry_out, op_out} against a bench model. The model steps the operand one bit at a time and takes its carry from the last bit moved, so the pair is checked as a whole rather than field by field.

// File: rtl/shifter_pkg.sv
// Shared types for the operand shifter.
// Assumes: operation codes are fixed as listed; codes 5..7 are unused.
package shifter_pkg;
    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_op_e;
endpackage

// File: rtl/opshf_amount_sel.sv
// Chooses the shift distance: the immediate field or the low byte of a register.
// Assumes: SEL_W >= IMM_W and SEL_W <= DATA_W.
module opshf_amount_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5,
    parameter int SEL_W  = 8
) (
    input  logic              amt_from_reg,
    input  logic [IMM_W-1:0]  imm_amt,
    input  logic [DATA_W-1:0] reg_amt,
    output logic [SEL_W-1:0]  amt
);
    localparam int PAD_W = SEL_W - IMM_W;

    logic unused_reg_hi;
    assign unused_reg_hi = ^reg_amt[DATA_W-1:SEL_W];

    // Pick the distance source; only the low SEL_W register bits matter.
    always_comb begin
        if (amt_from_reg)
            amt = reg_amt[SEL_W-1:0];
        else
            amt = {{PAD_W{1'b0}}, imm_amt};
    end
endmodule

// File: rtl/opshf_linear.sv
// Left shift, logical right shift and arithmetic right shift with carry.
// Assumes: distance is an unsigned SEL_W-bit value; zero passes the operand
// and carry; distances >= DATA_W saturate (zero or sign fill).
module opshf_linear
    import shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 8
) (
    input  shift_op_e         op_kind,
    input  logic [DATA_W-1:0] op_in,
    input  logic [SEL_W-1:0]  amt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              carry_out
);
    logic [DATA_W:0]        lsl_wide;
    logic [DATA_W:0]        lsr_wide;
    logic signed [DATA_W:0] asr_wide;

    // Widen by one bit so the last bit moved out lands in the extra position.
    always_comb begin
        lsl_wide = {1'b0, op_in} << amt;
        lsr_wide = {op_in, 1'b0} >> amt;
        asr_wide = $signed({op_in, 1'b0}) >>> amt;
    end

    // Select the result for the requested kind, with zero distance as pass-through.
    always_comb begin
        res       = op_in;
        carry_out = carry_in;
        if (amt != '0) begin
            case (op_kind)
                SH_LSL: begin
                    res       = lsl_wide[DATA_W-1:0];
                    carry_out = lsl_wide[DATA_W];
                end
                SH_LSR: begin
                    res       = lsr_wide[DATA_W:1];
                    carry_out = lsr_wide[0];
                end
                SH_ASR: begin
                    res       = asr_wide[DATA_W:1];
                    carry_out = asr_wide[0];
                end
                default: begin
                    res       = op_in;
                    carry_out = carry_in;
                end
            endcase
        end
    end
endmodule

// File: rtl/opshf_rotate.sv
// Rotate right by a distance, and one-place rotate through the carry.
// Assumes: DATA_W is a power of two, so distance modulo DATA_W is its low bits.
module opshf_rotate
    import shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 8
) (
    input  shift_op_e         op_kind,
    input  logic [DATA_W-1:0] op_in,
    input  logic [SEL_W-1:0]  amt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              carry_out
);
    localparam int ROT_W = $clog2(DATA_W);

    logic [ROT_W-1:0]    rot_n;
    logic [2*DATA_W-1:0] doubled;

    // Reduce the distance modulo the width and rotate through a doubled copy.
    always_comb begin
        rot_n   = amt[ROT_W-1:0];
        doubled = {op_in, op_in} >> rot_n;
    end

    // Form the rotate or the rotate-through-carry result and its carry.
    always_comb begin
        res       = op_in;
        carry_out = carry_in;
        if (op_kind == SH_RRX) begin
            res       = {carry_in, op_in[DATA_W-1:1]};
            carry_out = op_in[0];
        end else if (op_kind == SH_ROR && amt != '0) begin
            res       = doubled[DATA_W-1:0];
            carry_out = doubled[DATA_W-1];
        end
    end
endmodule

// File: rtl/operand_shifter.sv
// Top of the second-operand shifter: selects the distance, runs the linear
// and rotate units in parallel and steers the requested one to the outputs.
// Assumes: purely combinational; codes 5..7 pass operand and carry through.
module operand_shifter
    import shifter_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5,
    parameter int SEL_W  = 8
) (
    input  logic [DATA_W-1:0] op_in,
    input  logic [2:0]        shift_op,
    input  logic              amt_from_reg,
    input  logic [IMM_W-1:0]  imm_amt,
    input  logic [DATA_W-1:0] reg_amt,
    input  logic              carry_in,
    output logic [DATA_W-1:0] op_out,
    output logic              carry_out
);
    shift_op_e         kind;
    logic [SEL_W-1:0]  amt;
    logic [DATA_W-1:0] lin_res;
    logic              lin_c;
    logic [DATA_W-1:0] rot_res;
    logic              rot_c;

    assign kind = shift_op_e'(shift_op);

    opshf_amount_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SEL_W(SEL_W)) amt_i (
        .amt_from_reg (amt_from_reg),
        .imm_amt      (imm_amt),
        .reg_amt      (reg_amt),
        .amt          (amt)
    );

    opshf_linear #(.DATA_W(DATA_W), .SEL_W(SEL_W)) lin_i (
        .op_kind   (kind),
        .op_in     (op_in),
        .amt       (amt),
        .carry_in  (carry_in),
        .res       (lin_res),
        .carry_out (lin_c)
    );

    opshf_rotate #(.DATA_W(DATA_W), .SEL_W(SEL_W)) rot_i (
        .op_kind   (kind),
        .op_in     (op_in),
        .amt       (amt),
        .carry_in  (carry_in),
        .res       (rot_res),
        .carry_out (rot_c)
    );

    // Steer the unit that owns the requested operation to the outputs.
    always_comb begin
        case (shift_op)
            3'd0, 3'd1, 3'd2: begin
                op_out    = lin_res;
                carry_out = lin_c;
            end
            3'd3, 3'd4: begin
                op_out    = rot_res;
                carry_out = rot_c;
            end
            default: begin
                op_out    = op_in;
                carry_out = carry_in;
            end
        endcase
    end

    // Cross-unit checks between the distance selector, the units and the ports.
    always_comb begin
        if (amt == '0 && shift_op <= 3'd3) begin
            p_zero_pass_r1: assert (op_out == op_in && carry_out == carry_in)
                else $error("zero distance altered operand or carry");
        end
        if (shift_op == 3'd4) begin
            p_rrx_r6: assert (carry_out == op_in[0] && op_out[DATA_W-2:0] == op_in[DATA_W-1:1]
                              && op_out[DATA_W-1] == carry_in)
                else $error("rotate through carry mismatch");
        end
        if (shift_op == 3'd1 && amt != '0) begin
            p_lsr_zero_msb_r3: assert (op_out[DATA_W-1] == 1'b0)
                else $error("logical right shift left a set top bit");
        end
        if (shift_op == 3'd2) begin
            p_asr_sign_r4: assert (op_out[DATA_W-1] == op_in[DATA_W-1])
                else $error("arithmetic right shift lost the sign");
        end
        if (shift_op == 3'd3 && amt != '0) begin
            p_ror_carry_r5: assert (carry_out == op_out[DATA_W-1])
                else $error("rotate carry differs from result top bit");
        end
        if (shift_op <= 3'd1 && amt > SEL_W'(DATA_W)) begin
            p_big_logical_r8: assert (op_out == '0 && carry_out == 1'b0)
                else $error("oversize logical shift not cleared");
        end
        if (shift_op >= 3'd5) begin
            p_unused_code_r12: assert (op_out == op_in && carry_out == carry_in)
                else $error("unused code altered operand");
        end
    end
endmodule

// File: tb/operand_shifter_tb.sv
module operand_shifter_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [31:0] op_in;
    logic [2:0]  shift_op;
    logic        amt_from_reg;
    logic [4:0]  imm_amt;
    logic [31:0] reg_amt;
    logic        carry_in;
    logic [31:0] op_out;
    logic        carry_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    operand_shifter dut_i (
        .op_in        (op_in),
        .shift_op     (shift_op),
        .amt_from_reg (amt_from_reg),
        .imm_amt      (imm_amt),
        .reg_amt      (reg_amt),
        .carry_in     (carry_in),
        .op_out       (op_out),
        .carry_out    (carry_out)
    );

    // Bit-serial reference: moves one place per step, carry is the last bit moved.
    function automatic logic [32:0] model(logic [31:0] op, logic [2:0] k,
                                          logic [7:0] n, logic c);
        logic [31:0] v;
        logic        cy;
        v  = op;
        cy = c;
        case (k)
            3'd0: for (int i = 0; i < int'(n); i++) begin cy = v[31]; v = {v[30:0], 1'b0}; end
            3'd1: for (int i = 0; i < int'(n); i++) begin cy = v[0];  v = {1'b0, v[31:1]}; end
            3'd2: for (int i = 0; i < int'(n); i++) begin cy = v[0];  v = {v[31], v[31:1]}; end
            3'd3: for (int i = 0; i < int'(n); i++) begin cy = v[0];  v = {v[0], v[31:1]}; end
            3'd4: begin cy = op[0]; v = {c, op[31:1]}; end
            default: ;
        endcase
        return {cy, v};
    endfunction

    function automatic string req_of(logic [2:0] k, logic [7:0] n);
        if (k == 3'd4) return "R6";
        if (k > 3'd4) return "R12";
        if (n == 8'd0) return "R1";
        if (k == 3'd3) return (n[4:0] == 5'd0) ? "R10" : "R5";
        if (k == 3'd2) return (n >= 8'd32) ? "R9" : "R4";
        if (n == 8'd32) return "R7";
        if (n > 8'd32) return "R8";
        return (k == 3'd0) ? "R2" : "R3";
    endfunction

    task automatic run(logic [31:0] op, logic [2:0] k, logic src, logic [4:0] imm,
                       logic [31:0] rv, logic c, string tag);
        logic [7:0]  n;
        logic [32:0] exp;
        @(negedge clk);
        op_in = op; shift_op = k; amt_from_reg = src;
        imm_amt = imm; reg_amt = rv; carry_in = c;
        n   = src ? rv[7:0] : {3'b000, imm};
        exp = model(op, k, n, c);
        #5;
        n_checks++;
        if ({carry_out, op_out} !== exp) begin
            n_errors++;
            $display("FAIL %s: op=%h k=%0d n=%0d c=%b got c=%b r=%h exp c=%b r=%h",
                     (tag == "") ? req_of(k, n) : tag, op, k, n, c,
                     carry_out, op_out, exp[32], exp[31:0]);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] picks [8];
        picks = '{8'd0, 8'd31, 8'd32, 8'd33, 8'd64, 8'd96, 8'd255, 8'd1};
        op_in = '0; shift_op = '0; amt_from_reg = 1'b0;
        imm_amt = '0; reg_amt = '0; carry_in = 1'b0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state with all-zero inputs (R1).
        run(32'h0, 3'd0, 1'b0, 5'd0, 32'h0, 1'b0, "R1");
        // Directed corner cases.
        run(32'h8000_0001, 3'd0, 1'b0, 5'd0, 32'h0, 1'b1, "R1");
        run(32'hF000_000F, 3'd0, 1'b0, 5'd4, 32'h0, 1'b0, "R2");
        run(32'h8000_0001, 3'd1, 1'b0, 5'd1, 32'h0, 1'b0, "R3");
        run(32'h8000_0000, 3'd2, 1'b0, 5'd31, 32'h0, 1'b0, "R4");
        run(32'h1234_5678, 3'd3, 1'b0, 5'd8, 32'h0, 1'b0, "R5");
        run(32'h0000_0003, 3'd4, 1'b1, 5'd0, 32'h0000_0007, 1'b1, "R6");
        run(32'h0000_0001, 3'd0, 1'b1, 5'd0, 32'd32, 1'b0, "R7");
        run(32'h8000_0000, 3'd1, 1'b1, 5'd0, 32'd32, 1'b0, "R7");
        run(32'hFFFF_FFFF, 3'd0, 1'b1, 5'd0, 32'd33, 1'b1, "R8");
        run(32'hFFFF_FFFF, 3'd1, 1'b1, 5'd0, 32'd200, 1'b1, "R8");
        run(32'h8000_0000, 3'd2, 1'b1, 5'd0, 32'd32, 1'b0, "R9");
        run(32'h7FFF_FFFF, 3'd2, 1'b1, 5'd0, 32'd255, 1'b1, "R9");
        run(32'h8765_4321, 3'd3, 1'b1, 5'd0, 32'd64, 1'b0, "R10");
        run(32'h0765_4321, 3'd3, 1'b1, 5'd0, 32'd32, 1'b1, "R10");
        run(32'hA5A5_A5A5, 3'd1, 1'b1, 5'd0, 32'hFFFF_FF04, 1'b0, "R11");
        run(32'hA5A5_A5A5, 3'd0, 1'b1, 5'd0, 32'h1234_0000, 1'b1, "R11");
        run(32'hA5A5_A5A5, 3'd0, 1'b0, 5'd3, 32'hFFFF_FFFF, 1'b0, "R11");
        run(32'hDEAD_BEEF, 3'd5, 1'b0, 5'd7, 32'h0, 1'b1, "R12");
        run(32'hDEAD_BEEF, 3'd7, 1'b1, 5'd0, 32'd40, 1'b0, "R12");
        // Constrained random mix of distances and sources.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rv;
            rv = $urandom();
            if ($urandom_range(0, 3) != 0)
                rv[7:0] = picks[$urandom_range(0, 7)];
            run($urandom(), 3'($urandom_range(0, 7)), 1'($urandom()),
                5'($urandom()), rv, 1'($urandom()), "");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule